// File: doc/BRIEF.md
# Two-Level Address Translation Cache with Pinned Entries

This block caches virtual-to-physical page translations for a processor memory pipeline. It has two arrays that are searched in parallel. The main array is two-way set-associative and is filled by an external page-table walker. A small fully-associative pinned array holds entries that software places directly, so a lookup in those regions never needs a walk. Each lookup returns a hit or miss flag, the physical address, a domain number and a two-bit access-permission code.

Every entry records one of four mapping granules: a 1 MB section, a 64 KB large page, a 4 KB small page or a 1 KB tiny page. The comparison ignores the offset bits of that granule. Large and small pages carry four permission codes, one for each quarter of the page, and the quarter that the lookup address falls in selects the returned code. Main entries can be dropped all at once or one page at a time by address. Pinned entries change only through their own write port.

The walker and the permission logic around the block use the miss pulse and the returned fields. Page table walks, domain checks and fault generation happen outside this block.

Top module: `xlat_cache`

## Requirements
- R1: A lookup presented with `lk_req` high gives `rsp_valid` high in the next cycle only, with exactly one of `rsp_hit` and `rsp_miss` set. Without a request, `rsp_valid`, `rsp_hit` and `rsp_miss` stay low. Consecutive requests get consecutive responses.
- R2: The main array has 2 ways by SETS sets, indexed by `lk_va[SET_LO +: log2(SETS)]`. Each refill goes to the way named by a per-set replacement bit, and that bit then toggles. Two pages refilled into one set both hit, and a third refill replaces the older of the two.
- R3: The size code is 0 = 1 MB section (VA bits 31:20 compared), 1 = 64 KB large (31:16), 2 = 4 KB small (31:12), 3 = 1 KB tiny (31:10). On a hit, `rsp_pa` takes its stored bits above the granule offset and takes the offset bits from `lk_va`. An address outside the page misses.
- R4: The permission field is 8 bits, with quarter q in bits [2q+1:2q]. For large pages q = VA[15:14], for small pages q = VA[11:10]. Sections and tiny pages always return bits [1:0].
- R5: A hit returns the domain stored with the entry that hit.
- R6: `inv_all` clears every main entry. A refill in the same cycle is dropped, and pinned entries keep hitting.
- R7: `inv_va_en` clears only the main entries in the addressed set whose page contains `inv_vpn`. Other main entries and all pinned entries keep hitting.
- R8: `lock_we` with `lock_vld` high writes pinned slot `lock_idx`, and lookups in that page then hit with `rsp_locked` high and no miss pulse. With `lock_vld` low the slot is cleared.
- R9: When the pinned array and the main array both hit, the pinned entry's fields are returned with `rsp_locked` high.
- R10: Refills never replace or alter pinned entries, however many refills reach the same set.
- R11: After reset all entries are invalid, every lookup misses and `rsp_valid` is low.
- R12: When an invalidate-by-address and a refill arrive in the same cycle, both take effect, so the refilled page hits and the invalidated page misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Miss pulse; a walk is needed |
| rsp_locked | output | 1 | Hit came from the pinned array |
| rsp_pa | output | 32 | Physical address |
| rsp_dom | output | 4 | Domain of the hitting entry |
| rsp_ap | output | 2 | Selected access-permission code |
| fill_we | input | 1 | Refill write from the walker |
| fill_vpn | input | 22 | Refill virtual address bits 31:10 |
| fill_ppn | input | 22 | Refill physical base bits 31:10 |
| fill_size | input | 2 | Refill granule code |
| fill_dom | input | 4 | Refill domain |
| fill_ap | input | 8 | Refill permission codes, four quarters |
| inv_all | input | 1 | Drop all main entries |
| inv_va_en | input | 1 | Drop the main entry covering `inv_vpn` |
| inv_vpn | input | 22 | Invalidate address bits 31:10 |
| lock_we | input | 1 | Pinned-slot write |
| lock_idx | input | LK_W | Pinned slot number |
| lock_vld | input | 1 | 1 writes the slot, 0 clears it |
| lock_vpn | input | 22 | Pinned virtual address bits 31:10 |
| lock_ppn | input | 22 | Pinned physical base bits 31:10 |
| lock_size | input | 2 | Pinned granule code |
| lock_dom | input | 4 | Pinned domain |
| lock_ap | input | 8 | Pinned permission codes |

## Verification
The bench builds the block with SETS = 4, SET_LO = 12 and LOCK_N = 4. With these values every set, both ways of each set and every pinned slot can be filled and then evicted in a short run. The sweep places one entry of each granule in its own set and probes it with address patterns that reach all four permission quarters and the first address past the page. With only four sets, refills collide with pinned pages and with invalidated pages quickly, so the replacement order, the pinned-over-main priority and the same-cycle invalidate-and-refill cases are all reached.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W  = 32;
  localparam int PG_LO = 10;             // finest granule (1 KB)
  localparam int TAG_W = VA_W - PG_LO;
  localparam int DOM_W = 4;
  localparam int AP_W  = 2;
  localparam int QTR_N = 4;

  typedef enum logic [1:0] {
    PG_SECT  = 2'd0,
    PG_LARGE = 2'd1,
    PG_SMALL = 2'd2,
    PG_TINY  = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic [TAG_W-1:0]      vtag;
    logic [TAG_W-1:0]      pbase;
    pg_size_e              size;
    logic [DOM_W-1:0]      dom;
    logic [QTR_N*AP_W-1:0] ap;
  } xlat_ent_t;

  // granule-unit offset bits hidden by each mapping size
  function automatic int off_bits(pg_size_e sz);
    case (sz)
      PG_SECT:  return 10;
      PG_LARGE: return 6;
      PG_SMALL: return 2;
      default:  return 0;
    endcase
  endfunction

  function automatic logic [TAG_W-1:0] cmp_mask(pg_size_e sz);
    logic [TAG_W-1:0] m;
    m = '1;
    return m << off_bits(sz);
  endfunction

  function automatic logic ent_hit(xlat_ent_t e, logic [TAG_W-1:0] vpn);
    return ((e.vtag ^ vpn) & cmp_mask(e.size)) == '0;
  endfunction

  function automatic logic [VA_W-1:0] make_pa(xlat_ent_t e, logic [VA_W-1:0] va);
    logic [TAG_W-1:0] m;
    m = cmp_mask(e.size);
    return {(e.pbase & m) | (va[VA_W-1:PG_LO] & ~m), va[PG_LO-1:0]};
  endfunction

  function automatic logic [AP_W-1:0] pick_ap(xlat_ent_t e, logic [VA_W-1:0] va);
    logic [1:0] q;
    case (e.size)
      PG_LARGE: q = va[15:14];
      PG_SMALL: q = va[11:10];
      default:  q = 2'd0;
    endcase
    return e.ap[q*AP_W +: AP_W];
  endfunction
endpackage

// File: rtl/xlat_main_ways.sv
module xlat_main_ways
  import xlat_pkg::*;
#(
  parameter int SETS   = 32,
  parameter int SET_LO = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] look_vpn,
  output logic             hit,
  output xlat_ent_t        hit_ent,
  input  logic             fill_we,
  input  xlat_ent_t        fill_ent,
  input  logic             inv_all,
  input  logic             inv_va_en,
  input  logic [TAG_W-1:0] inv_vpn
);
  localparam int WAYS    = 2;
  localparam int SET_W   = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int IDX_OFS = SET_LO - PG_LO;

  logic [WAYS-1:0][SETS-1:0] vld_q, vld_d;
  logic [SETS-1:0]           rr_q, rr_d;
  logic [SET_W-1:0]          look_set, inv_set, fill_set;
  logic [WAYS-1:0]           way_hit, way_kill;
  xlat_ent_t                 rd_look [WAYS];
  logic                      victim;
  logic                      fill_wr;

  assign look_set = look_vpn[IDX_OFS +: SET_W];
  assign inv_set  = inv_vpn[IDX_OFS +: SET_W];
  assign fill_set = fill_ent.vtag[IDX_OFS +: SET_W];
  assign victim   = rr_q[fill_set];
  assign fill_wr  = fill_we & ~inv_all;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    xlat_ent_t mem_q [SETS];
    logic      wr_en;

    assign wr_en       = fill_wr & (victim == (w != 0));
    assign rd_look[w]  = mem_q[look_set];
    assign way_hit[w]  = vld_q[w][look_set] & ent_hit(mem_q[look_set], look_vpn);
    assign way_kill[w] = inv_va_en & vld_q[w][inv_set] & ent_hit(mem_q[inv_set], inv_vpn);

    always_ff @(posedge clk) begin
      if (wr_en) mem_q[fill_set] <= fill_ent;
    end
  end

  assign hit     = |way_hit;
  assign hit_ent = way_hit[0] ? rd_look[0] : rd_look[1];

  always_comb begin
    vld_d = vld_q;
    rr_d  = rr_q;
    if (inv_all) begin
      vld_d = '0;
    end else begin
      for (int w = 0; w < WAYS; w++) begin
        if (way_kill[w]) vld_d[w][inv_set] = 1'b0;
      end
      if (fill_we) begin
        vld_d[victim][fill_set] = 1'b1;
        rr_d[fill_set]          = ~victim;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
  end
endmodule

// File: rtl/xlat_lock_cam.sv
module xlat_lock_cam
  import xlat_pkg::*;
#(
  parameter int LOCK_N = 8,
  parameter int IDX_W  = (LOCK_N > 1) ? $clog2(LOCK_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] look_vpn,
  output logic             hit,
  output xlat_ent_t        hit_ent,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_vld,
  input  xlat_ent_t        wr_ent
);
  logic [LOCK_N-1:0] vld_q, vld_d;
  logic [LOCK_N-1:0] slot_hit;
  xlat_ent_t         rd [LOCK_N];

  for (genvar s = 0; s < LOCK_N; s++) begin : g_slot
    xlat_ent_t slot_q;
    logic      sel;

    assign sel         = wr_en & (wr_idx == IDX_W'(s));
    assign rd[s]       = slot_q;
    assign slot_hit[s] = vld_q[s] & ent_hit(slot_q, look_vpn);

    always_ff @(posedge clk) begin
      if (sel && wr_vld) slot_q <= wr_ent;
    end
  end

  always_comb begin
    vld_d = vld_q;
    for (int s = 0; s < LOCK_N; s++) begin
      if (wr_en && (wr_idx == IDX_W'(s))) vld_d[s] = wr_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // lowest-numbered slot wins if several overlap
  always_comb begin
    hit_ent = '0;
    for (int s = LOCK_N - 1; s >= 0; s--) begin
      if (slot_hit[s]) hit_ent = rd[s];
    end
  end

  assign hit = |slot_hit;
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int SETS   = 32,
  parameter int SET_LO = 12,
  parameter int LOCK_N = 8,
  parameter int LK_W   = (LOCK_N > 1) ? $clog2(LOCK_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_va,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_locked,
  output logic [VA_W-1:0]   rsp_pa,
  output logic [DOM_W-1:0]  rsp_dom,
  output logic [AP_W-1:0]   rsp_ap,
  input  logic              fill_we,
  input  logic [TAG_W-1:0]  fill_vpn,
  input  logic [TAG_W-1:0]  fill_ppn,
  input  logic [1:0]        fill_size,
  input  logic [DOM_W-1:0]  fill_dom,
  input  logic [QTR_N*AP_W-1:0] fill_ap,
  input  logic              inv_all,
  input  logic              inv_va_en,
  input  logic [TAG_W-1:0]  inv_vpn,
  input  logic              lock_we,
  input  logic [LK_W-1:0]   lock_idx,
  input  logic              lock_vld,
  input  logic [TAG_W-1:0]  lock_vpn,
  input  logic [TAG_W-1:0]  lock_ppn,
  input  logic [1:0]        lock_size,
  input  logic [DOM_W-1:0]  lock_dom,
  input  logic [QTR_N*AP_W-1:0] lock_ap
);
  xlat_ent_t fill_ent, lock_ent, main_ent, pin_ent, sel_ent;
  logic      main_hit_c, lock_hit_c, any_hit_c;

  logic            vld_q, hit_q, lkd_q;
  logic            vld_d, hit_d, lkd_d;
  logic [VA_W-1:0] pa_q, pa_d;
  logic [DOM_W-1:0] dom_q, dom_d;
  logic [AP_W-1:0] ap_q, ap_d;

  assign fill_ent = '{vtag: fill_vpn, pbase: fill_ppn, size: pg_size_e'(fill_size),
                      dom: fill_dom, ap: fill_ap};
  assign lock_ent = '{vtag: lock_vpn, pbase: lock_ppn, size: pg_size_e'(lock_size),
                      dom: lock_dom, ap: lock_ap};

  xlat_main_ways #(.SETS(SETS), .SET_LO(SET_LO)) u_main (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_vpn (lk_va[VA_W-1:PG_LO]),
    .hit      (main_hit_c),
    .hit_ent  (main_ent),
    .fill_we  (fill_we),
    .fill_ent (fill_ent),
    .inv_all  (inv_all),
    .inv_va_en(inv_va_en),
    .inv_vpn  (inv_vpn)
  );

  xlat_lock_cam #(.LOCK_N(LOCK_N), .IDX_W(LK_W)) u_pin (
    .clk     (clk),
    .rst_n   (rst_n),
    .look_vpn(lk_va[VA_W-1:PG_LO]),
    .hit     (lock_hit_c),
    .hit_ent (pin_ent),
    .wr_en   (lock_we),
    .wr_idx  (lock_idx),
    .wr_vld  (lock_vld),
    .wr_ent  (lock_ent)
  );

  assign any_hit_c = main_hit_c | lock_hit_c;
  assign sel_ent   = lock_hit_c ? pin_ent : main_ent;

  always_comb begin
    vld_d = lk_req;
    hit_d = lk_req & any_hit_c;
    lkd_d = lk_req & lock_hit_c;
    pa_d  = any_hit_c ? make_pa(sel_ent, lk_va) : '0;
    dom_d = any_hit_c ? sel_ent.dom : '0;
    ap_d  = any_hit_c ? pick_ap(sel_ent, lk_va) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      hit_q <= 1'b0;
      lkd_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      hit_q <= hit_d;
      lkd_q <= lkd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_req) begin
      pa_q  <= pa_d;
      dom_q <= dom_d;
      ap_q  <= ap_d;
    end
  end

  assign rsp_valid  = vld_q;
  assign rsp_hit    = hit_q;
  assign rsp_miss   = vld_q & ~hit_q;
  assign rsp_locked = lkd_q;
  assign rsp_pa     = pa_q;
  assign rsp_dom    = dom_q;
  assign rsp_ap     = ap_q;
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk (
  input logic clk,
  input logic rst_n,
  input logic lk_req,
  input logic inv_all,
  input logic lock_hit_c,
  input logic rsp_valid,
  input logic rsp_hit,
  input logic rsp_miss,
  input logic rsp_locked
);
  logic inv_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inv_prev_q <= 1'b0;
    else        inv_prev_q <= inv_all;
  end

  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_valid);
  p_hit_xor_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_miss));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_miss && !rsp_locked));
  p_pin_nomiss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_locked |-> (rsp_hit && !rsp_miss));
  p_pin_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && lock_hit_c) |=> (rsp_hit && rsp_locked));
  p_flush_main_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_prev_q && lk_req && !lock_hit_c) |=> !rsp_hit);
endmodule

bind xlat_cache xlat_cache_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_req    (lk_req),
  .inv_all   (inv_all),
  .lock_hit_c(lock_hit_c),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_miss  (rsp_miss),
  .rsp_locked(rsp_locked)
);

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
module test_xlat_cache;
  localparam int SETS = 4, SET_LO = 12, LOCK_N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_va = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_locked;
  logic [31:0] rsp_pa;
  logic [3:0]  rsp_dom;
  logic [1:0]  rsp_ap;
  logic        fill_we = 1'b0;
  logic [21:0] fill_vpn = '0, fill_ppn = '0;
  logic [1:0]  fill_size = '0;
  logic [3:0]  fill_dom = '0;
  logic [7:0]  fill_ap = '0;
  logic        inv_all = 1'b0, inv_va_en = 1'b0;
  logic [21:0] inv_vpn = '0;
  logic        lock_we = 1'b0, lock_vld = 1'b0;
  logic [1:0]  lock_idx = '0;
  logic [21:0] lock_vpn = '0, lock_ppn = '0;
  logic [1:0]  lock_size = '0;
  logic [3:0]  lock_dom = '0;
  logic [7:0]  lock_ap = '0;

  int n_chk = 0, n_err = 0;
  logic [31:0] fva, pb, va;

  always #4 clk = ~clk;

  xlat_cache #(.SETS(SETS), .SET_LO(SET_LO), .LOCK_N(LOCK_N)) i_xlat_cache (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_locked(rsp_locked),
    .rsp_pa(rsp_pa), .rsp_dom(rsp_dom), .rsp_ap(rsp_ap),
    .fill_we(fill_we), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_size(fill_size),
    .fill_dom(fill_dom), .fill_ap(fill_ap),
    .inv_all(inv_all), .inv_va_en(inv_va_en), .inv_vpn(inv_vpn),
    .lock_we(lock_we), .lock_idx(lock_idx), .lock_vld(lock_vld), .lock_vpn(lock_vpn),
    .lock_ppn(lock_ppn), .lock_size(lock_size), .lock_dom(lock_dom), .lock_ap(lock_ap)
  );

  function automatic logic [31:0] om(input int sz);
    case (sz)
      0:       return 32'h000F_FFFF;
      1:       return 32'h0000_FFFF;
      2:       return 32'h0000_0FFF;
      default: return 32'h0000_03FF;
    endcase
  endfunction

  function automatic logic [1:0] eap(input logic [7:0] ap, input int sz, input logic [31:0] a);
    int q;
    q = (sz == 1) ? int'(a[15:14]) : (sz == 2) ? int'(a[11:10]) : 0;
    return ap[2*q +: 2];
  endfunction

  function automatic logic [31:0] pat(input int i);
    case (i)
      0:       return 32'h0000_0000;
      1:       return 32'hFFFF_FFFF;
      2:       return 32'h5555_5555;
      3:       return 32'hAAAA_AAAA;
      4:       return 32'h0000_C400;
      default: return 32'h0000_4BCD;
    endcase
  endfunction

  function automatic logic [31:0] pg(input int s, input int k);
    return 32'h1000_0000 * (k + 1) + (s << 12);
  endfunction

  function automatic logic [31:0] lva(input int i);
    return 32'h7000_0400 + i * 32'h1000;
  endfunction

  function automatic logic [31:0] lpa(input int i);
    return 32'h3000_0800 + (i << 16);
  endfunction

  task automatic check(input logic ok, input string tag, input string msg);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  task automatic fill(input logic [31:0] v, input logic [31:0] p, input int sz,
                      input logic [3:0] d, input logic [7:0] ap);
    fill_we = 1'b1; fill_vpn = v[31:10]; fill_ppn = p[31:10];
    fill_size = 2'(sz); fill_dom = d; fill_ap = ap;
    @(posedge clk); @(negedge clk);
    fill_we = 1'b0;
  endtask

  task automatic pin(input int idx, input logic vld, input logic [31:0] v, input logic [31:0] p,
                     input int sz, input logic [3:0] d, input logic [7:0] ap);
    lock_we = 1'b1; lock_idx = 2'(idx); lock_vld = vld; lock_vpn = v[31:10];
    lock_ppn = p[31:10]; lock_size = 2'(sz); lock_dom = d; lock_ap = ap;
    @(posedge clk); @(negedge clk);
    lock_we = 1'b0;
  endtask

  task automatic inv_addr(input logic [31:0] v);
    inv_va_en = 1'b1; inv_vpn = v[31:10];
    @(posedge clk); @(negedge clk);
    inv_va_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] v, input logic eh, input logic el, input logic [31:0] epa,
                      input logic [3:0] ed, input logic [1:0] ea, input string tag);
    logic ok;
    lk_req = 1'b1; lk_va = v;
    @(posedge clk); @(negedge clk);
    lk_req = 1'b0;
    ok = (rsp_valid === 1'b1) && (rsp_hit === eh) && (rsp_miss === !eh);
    if (eh) ok = ok && (rsp_locked === el) && (rsp_pa === epa) && (rsp_dom === ed) && (rsp_ap === ea);
    else    ok = ok && (rsp_locked === 1'b0);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s va=%h act v=%b h=%b m=%b l=%b pa=%h dom=%h ap=%h exp h=%b l=%b pa=%h dom=%h ap=%h",
               tag, v, rsp_valid, rsp_hit, rsp_miss, rsp_locked, rsp_pa, rsp_dom, rsp_ap,
               eh, el, epa, ed, ea);
    end
  endtask

  task automatic hitm(input logic [31:0] v, input logic [31:0] p, input int sz, input logic [3:0] d,
                      input logic [7:0] ap, input logic el, input string tag);
    look(v, 1'b1, el, (p & ~om(sz)) | (v & om(sz)), d, eap(ap, sz, v), tag);
  endtask

  task automatic missm(input logic [31:0] v, input string tag);
    look(v, 1'b0, 1'b0, '0, '0, '0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R1 watchdog expired act=running exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    check(rsp_valid === 1'b0 && rsp_miss === 1'b0 && rsp_hit === 1'b0, "R11",
          $sformatf("act v=%b h=%b m=%b exp 0 0 0", rsp_valid, rsp_hit, rsp_miss));
    for (int s = 0; s < SETS; s++) missm(32'h4000_0000 | (s << 12), "R11 empty after reset");

    // R3 R4 R5: one entry per granule, own set, probe patterns
    for (int s = 0; s < 4; s++) begin
      fva = 32'h4000_0000 + s * 32'h0100_0000 + (s << 12);
      pb  = 32'h9ABC_DC00 ^ (s << 24);
      fill(fva, pb, s, 4'(s + 5), 8'h1B);
      for (int i = 0; i < 6; i++) begin
        va = fva ^ (pat(i) & om(s) & ~32'h0000_3000);
        hitm(va, pb, s, 4'(s + 5), 8'h1B, 1'b0, "R3 R4 R5 in-page probe");
      end
      missm(fva ^ (om(s) + 1), "R3 first page past the entry");
    end

    // R1: idle cycle after a response, then back-to-back requests
    @(posedge clk); @(negedge clk);
    check(rsp_valid === 1'b0 && rsp_miss === 1'b0, "R1",
          $sformatf("idle act v=%b m=%b exp 0 0", rsp_valid, rsp_miss));
    fva = 32'h4200_2000;
    hitm(fva, 32'h9ABC_DC00 ^ (2 << 24), 2, 4'd7, 8'h1B, 1'b0, "R1 back-to-back first");
    missm(32'h4300_2000, "R1 back-to-back second");

    // R6: pin one entry, flush main
    pin(0, 1'b1, lva(0), lpa(0), 3, 4'd12, 8'hC6);
    inv_all = 1'b1; @(posedge clk); @(negedge clk); inv_all = 1'b0;
    for (int s = 0; s < 4; s++)
      missm(32'h4000_0000 + s * 32'h0100_0000 + (s << 12), "R6 main flushed");
    hitm(lva(0) + 32'h1F3, lpa(0), 3, 4'd12, 8'hC6, 1'b1, "R6 pinned survives flush");

    // R2: replacement sweep over every set
    for (int s = 0; s < SETS; s++) begin
      fill(pg(s, 0), pg(s, 0) ^ 32'hC000_0000, 2, 4'd0, 8'h1B);
      fill(pg(s, 1), pg(s, 1) ^ 32'hC000_0000, 2, 4'd1, 8'h1B);
      hitm(pg(s, 0) + 32'h7FF, pg(s, 0) ^ 32'hC000_0000, 2, 4'd0, 8'h1B, 1'b0, "R2 way A");
      hitm(pg(s, 1) + 32'hC12, pg(s, 1) ^ 32'hC000_0000, 2, 4'd1, 8'h1B, 1'b0, "R2 way B");
      fill(pg(s, 2), pg(s, 2) ^ 32'hC000_0000, 2, 4'd2, 8'h1B);
      missm(pg(s, 0), "R2 oldest evicted");
      hitm(pg(s, 1), pg(s, 1) ^ 32'hC000_0000, 2, 4'd1, 8'h1B, 1'b0, "R2 survivor");
      hitm(pg(s, 2) + 32'h4AB, pg(s, 2) ^ 32'hC000_0000, 2, 4'd2, 8'h1B, 1'b0, "R2 newest");
    end

    // R7: invalidate by address
    inv_addr(pg(0, 1) | 32'h0000_0ABC);
    missm(pg(0, 1), "R7 addressed page dropped");
    hitm(pg(0, 2), pg(0, 2) ^ 32'hC000_0000, 2, 4'd2, 8'h1B, 1'b0, "R7 neighbour kept");
    inv_addr(32'h6000_0000);
    hitm(pg(0, 2), pg(0, 2) ^ 32'hC000_0000, 2, 4'd2, 8'h1B, 1'b0, "R7 unmatched address");
    fill(32'h5000_3000, 32'h2222_0000, 1, 4'd9, 8'h1B);
    hitm(32'h5000_F3FF, 32'h2222_0000, 1, 4'd9, 8'h1B, 1'b0, "R7 large page present");
    inv_addr(32'h5000_B7FF);
    missm(32'h5000_F3FF, "R7 large page dropped by inner address");
    hitm(pg(3, 2), pg(3, 2) ^ 32'hC000_0000, 2, 4'd2, 8'h1B, 1'b0, "R7 same-set other page");

    // R8 R9 R10: pinned slots
    fill(lva(2), 32'h5555_5000, 2, 4'd3, 8'h1B);
    for (int i = 1; i < LOCK_N; i++) pin(i, 1'b1, lva(i), lpa(i), 3, 4'(12 + i), 8'hC6);
    for (int i = 0; i < LOCK_N; i++)
      hitm(lva(i) + 32'h1F3, lpa(i), 3, 4'(12 + i), 8'hC6, 1'b1, "R8 R9 pinned hit");
    inv_addr(lva(1));
    hitm(lva(1), lpa(1), 3, 4'd13, 8'hC6, 1'b1, "R7 pinned ignores address invalidate");
    pin(2, 1'b0, lva(2), lpa(2), 3, 4'd0, 8'h00);
    hitm(lva(2) + 32'h1F3, 32'h5555_5000, 2, 4'd3, 8'h1B, 1'b0, "R8 cleared slot, main answers");
    fill(32'h0D00_3000, 32'h0D00_3000, 2, 4'd4, 8'h1B);
    fill(32'h0E00_3000, 32'h0E00_3000, 2, 4'd5, 8'h1B);
    fill(32'h0F00_3000, 32'h0F00_3000, 2, 4'd6, 8'h1B);
    hitm(lva(3) + 32'h0AA, lpa(3), 3, 4'd15, 8'hC6, 1'b1, "R10 pinned survives refills");
    hitm(32'h0F00_3ABC, 32'h0F00_3000, 2, 4'd6, 8'h1B, 1'b0, "R10 refill landed in main");

    // R12: same-cycle address invalidate and refill
    fill(32'h0A00_2000, 32'h1A00_2000, 2, 4'd1, 8'h1B);
    inv_va_en = 1'b1; inv_vpn = 22'(32'h0A00_2000 >> 10);
    fill(32'h0B00_2000, 32'h1B00_2000, 2, 4'd2, 8'h1B);
    inv_va_en = 1'b0;
    missm(32'h0A00_2000, "R12 invalidated page");
    hitm(32'h0B00_2123, 32'h1B00_2000, 2, 4'd2, 8'h1B, 1'b0, "R12 refilled page");

    // R6: flush with simultaneous refill drops the refill
    inv_all = 1'b1;
    fill(32'h0C00_1000, 32'h1C00_1000, 2, 4'd3, 8'h1B);
    inv_all = 1'b0;
    missm(32'h0C00_1000, "R6 refill in flush cycle dropped");
    missm(32'h0B00_2000, "R6 earlier main entry flushed");
    hitm(lva(1), lpa(1), 3, 4'd13, 8'hC6, 1'b1, "R6 pinned slot kept");
    missm(lva(2), "R8 cleared slot stays clear");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule